// File: doc/BRIEF.md
# Peripheral-Paced Single-Channel DMA Engine

This block is one DMA channel that copies a run of data elements from a source region to a destination region. Each element waits for a request from a peripheral. The channel then reads the element over a single-beat memory bus, writes it to the destination, and acknowledges the request. Software sets the start addresses, the element count, the element width and a separate address mode for each side. It then sets a trigger bit, which the engine clears when the run ends.

Each side can advance by the element size, stay fixed, or run in a looping mode. In the looping mode the channel rewinds to its programmed start and begins a new pass with no new trigger, for as long as the channel stays enabled. A bus error response latches an abort state. The channel then accepts no further trigger until a software reset, which clears the engine and its pointers but leaves the configuration inputs alone. The source and destination start addresses must be word aligned.

Top module: `periph_dma_chan`

## Requirements
- R1: After `rst_n` is low, `trig_busy`, `bus_req`, `prq_ack`, `done_evt`, `abort_flag` and `sw_rst_busy` are 0, and `cur_src`, `cur_dst` and `cur_cnt` are 0.
- R2: The width code `cfg_width` sets the element size. 2'b00 is 4 bytes with `bus_size`=2, 2'b01 is 1 byte with `bus_size`=0, 2'b10 is 2 bytes with `bus_size`=1, and the reserved 2'b11 behaves as 4 bytes. Element data is right-aligned in the low bits of `bus_rdata` and `bus_wdata`.
- R3: Each side has a mode code. 2'b00 advances that side's address by the element size after each element, and 2'b10 holds it fixed. The reserved 2'b01 behaves as fixed, and 2'b11 advances like 2'b00.
- R4: Each element waits for `prq_req` while enabled, reads the source, writes the destination, then gives a one-cycle `prq_ack`. `cur_cnt` shows the number of elements still to move.
- R5: At start, `cur_src` and `cur_dst` load the programmed bases. After that they show the source and destination addresses of the most recent completed read and write.
- R6: A pulse on `trig_set` sets `trig_busy`. The run starts when `trig_busy` and `cfg_enable` are both high, and `cur_cnt` then loads `cfg_count`. When the count reaches zero outside wrap mode, `done_evt` pulses for one cycle and `trig_busy` clears. A programmed count of zero completes at once with no bus access.
- R7: If either side uses mode 2'b11 (wrap), `cur_cnt` reloads from `cfg_count` when it reaches zero, and each wrapping side's address rewinds to its base. No `done_evt` is given, and the next pass runs with no new trigger.
- R8: While `cfg_enable` is low, no bus access starts and requests are not served; a triggered channel waits. Clearing `cfg_enable` during a run ends it without `done_evt`, `trig_busy` clears, and `cur_cnt` keeps its value.
- R9: If `cfg_enable` is low when a read completes, the read data is dropped. No write follows, no acknowledge is given, and `cur_cnt` is unchanged.
- R10: A `bus_err` on a read or a write sets `abort_flag`, clears `trig_busy` and leaves the bus idle. The failed element is not acknowledged or counted, and `abort_flag` holds until a software reset.
- R11: While `abort_flag` is high, `trig_set` has no effect.
- R12: A `sw_rst_req` pulse holds `sw_rst_busy` high for RST_CYC cycles (default 3). This clears the engine state, `trig_busy`, `abort_flag`, the data buffer, `cur_src`, `cur_dst` and `cur_cnt`.
- R13: Once raised, `bus_req` stays high with `bus_addr` and `bus_we` stable until `bus_ready` or `bus_err` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_src_mode | input | 2 | Source address mode |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_width | input | 2 | Element width code |
| cfg_src_base | input | AW | Programmed source start address |
| cfg_dst_base | input | AW | Programmed destination start address |
| cfg_count | input | CW | Programmed element count |
| trig_set | input | 1 | Pulse that sets the trigger bit |
| sw_rst_req | input | 1 | Pulse that starts a software reset |
| trig_busy | output | 1 | Trigger bit, self-clearing |
| sw_rst_busy | output | 1 | Software reset in progress |
| abort_flag | output | 1 | Latched bus-error abort |
| done_evt | output | 1 | One-cycle completion event |
| cur_src | output | AW | Source address of the last element |
| cur_dst | output | AW | Destination address of the last element |
| cur_cnt | output | CW | Elements remaining |
| prq_req | input | 1 | Peripheral request |
| prq_ack | output | 1 | Peripheral acknowledge pulse |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus byte address |
| bus_size | output | 2 | 0 byte, 1 half-word, 2 word |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |

## Verification
The copy function is run over a table of runs. Each run differs from the others in one respect: the width code (including the reserved code), the source mode or the destination mode (including the reserved mode). A wrong step, a side that moves when it should stay fixed, or the reverse, therefore shows up in the destination bytes and the final current addresses. The bench also drives a wrap pass that crosses two reloads while the destination keeps advancing, which separates rewinding the source from restarting the whole run. Further directed runs target the enable gate in three places: before start, while waiting, and with a read in flight. Bus errors are injected on a read and on a write. Each of these leaves a different pattern of count, acknowledges and memory contents.

// File: rtl/dch_pkg.sv
// Shared types and decode helpers for the DMA channel engine.
// Assumes: element sizes of at most 4 bytes.
package dch_pkg;

    typedef enum logic [1:0] {
        AM_INC  = 2'b00,
        AM_RSV  = 2'b01,
        AM_FIX  = 2'b10,
        AM_WRAP = 2'b11
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_WR,
        ST_ACK,
        ST_ABT
    } st_e;

    // Byte step for a width code; the reserved code acts as a word.
    function automatic logic [2:0] width_step(input logic [1:0] w);
        case (w)
            2'b01:   return 3'd1;
            2'b10:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Bus size code for a width code.
    function automatic logic [1:0] width_size(input logic [1:0] w);
        case (w)
            2'b01:   return 2'd0;
            2'b10:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // True when the mode moves the address after each element.
    function automatic logic mode_moves(input logic [1:0] m);
        return (m == AM_INC) || (m == AM_WRAP);
    endfunction

endpackage

// File: rtl/dch_addr_gen.sv
// Address pointer for one side of the channel.
// Holds the next address to use (ptr) and the address of the last
// completed access (shown). Assumes load, adv and reload come from the
// controller and never load together with adv.
module dch_addr_gen
    import dch_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic          adv,
    input  logic          reload,
    input  logic [1:0]    mode,
    input  logic [2:0]    step,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] shown
);

    logic [AW-1:0] step_ext;

    // Widen the byte step to the address width.
    always_comb step_ext = {{(AW-3){1'b0}}, step};

    // Load, advance or rewind the pointer and record the used address.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr   <= '0;
            shown <= '0;
        end else if (load) begin
            ptr   <= base;
            shown <= base;
        end else begin
            if (adv) begin
                shown <= ptr;
                if (mode_moves(mode))
                    ptr <= ptr + step_ext;
            end
            if (reload && (mode == AM_WRAP))
                ptr <= base;
        end
    end

endmodule

// File: rtl/dch_soft_rst.sv
// Stretches a software reset request into a busy window of RST_CYC cycles.
// Assumes RST_CYC >= 1. A request during the window restarts it.
module dch_soft_rst #(
    parameter int RST_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy
);

    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] cnt;

    // Count the remaining cycles of the reset window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (req)
            cnt <= CW'(RST_CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // The window is active while the count is nonzero.
    always_comb busy = (cnt != '0);

endmodule

// File: rtl/dch_ctrl.sv
// Channel sequencer: trigger bit, per-element read/write/ack sequence,
// remaining count, wrap reload, disable handling and abort latch.
// Assumes configuration inputs are static while a run is active.
module dch_ctrl
    import dch_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          enable,
    input  logic [1:0]    smode,
    input  logic [1:0]    dmode,
    input  logic [CW-1:0] cfg_count,
    input  logic          trig_set,
    input  logic          prq_req,
    input  logic          bus_ready,
    input  logic          bus_err,
    input  logic [DW-1:0] bus_rdata,
    output logic          trig_busy,
    output logic          abort_flag,
    output logic [CW-1:0] cur_cnt,
    output logic          load,
    output logic          src_adv,
    output logic          dst_adv,
    output logic          wrap_evt,
    output logic          bus_req,
    output logic          bus_we,
    output logic [DW-1:0] wdata,
    output logic          prq_ack,
    output logic          done_evt
);

    st_e           state;
    logic          trig_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] buf_q;
    logic          wrap_mode;
    logic          start;
    logic          rd_ok;
    logic          wr_ok;
    logic          last;

    // Decode the current step of the sequence into strobes and outputs.
    always_comb begin
        wrap_mode  = (smode == AM_WRAP) || (dmode == AM_WRAP);
        start      = (state == ST_IDLE) && trig_q && enable;
        rd_ok      = (state == ST_RD) && bus_ready && !bus_err;
        wr_ok      = (state == ST_WR) && bus_ready && !bus_err;
        last       = (cnt_q == CW'(1));
        load       = start;
        src_adv    = rd_ok && enable;
        dst_adv    = wr_ok;
        wrap_evt   = wr_ok && last && wrap_mode;
        bus_req    = (state == ST_RD) || (state == ST_WR);
        bus_we     = (state == ST_WR);
        wdata      = buf_q;
        prq_ack    = (state == ST_ACK);
        done_evt   = (start && (cfg_count == '0)) ||
                     ((state == ST_ACK) && (cnt_q == '0));
        trig_busy  = trig_q;
        abort_flag = (state == ST_ABT);
        cur_cnt    = cnt_q;
    end

    // Advance the channel state machine and its count and buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state  <= ST_IDLE;
            trig_q <= 1'b0;
            cnt_q  <= '0;
            buf_q  <= '0;
        end else begin
            if (trig_set && (state != ST_ABT))
                trig_q <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q <= cfg_count;
                        if (cfg_count == '0)
                            trig_q <= 1'b0;
                        else
                            state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!enable) begin
                        state  <= ST_IDLE;
                        trig_q <= 1'b0;
                    end else if (prq_req) begin
                        state <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (bus_err) begin
                        state  <= ST_ABT;
                        trig_q <= 1'b0;
                    end else if (bus_ready) begin
                        if (!enable) begin
                            state  <= ST_IDLE;
                            trig_q <= 1'b0;
                        end else begin
                            buf_q <= bus_rdata;
                            state <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (bus_err) begin
                        state  <= ST_ABT;
                        trig_q <= 1'b0;
                    end else if (bus_ready) begin
                        cnt_q <= (last && wrap_mode) ? cfg_count : cnt_q - 1'b1;
                        state <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if ((cnt_q == '0) || !enable) begin
                        state  <= ST_IDLE;
                        trig_q <= 1'b0;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                default: begin
                    trig_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/periph_dma_chan.sv
// Top of one peripheral-paced DMA channel: joins the sequencer, the two
// address pointers and the software reset stretcher, and forms the bus
// address and size. Assumes word-aligned bases and DW >= 32.
module periph_dma_chan
    import dch_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int CW      = 16,
    parameter int RST_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic [1:0]    cfg_src_mode,
    input  logic [1:0]    cfg_dst_mode,
    input  logic [1:0]    cfg_width,
    input  logic [AW-1:0] cfg_src_base,
    input  logic [AW-1:0] cfg_dst_base,
    input  logic [CW-1:0] cfg_count,
    input  logic          trig_set,
    input  logic          sw_rst_req,
    output logic          trig_busy,
    output logic          sw_rst_busy,
    output logic          abort_flag,
    output logic          done_evt,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] cur_cnt,
    input  logic          prq_req,
    output logic          prq_ack,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    input  logic          bus_err
);

    logic          load;
    logic          src_adv;
    logic          dst_adv;
    logic          wrap_evt;
    logic [2:0]    step;
    logic [AW-1:0] src_ptr;
    logic [AW-1:0] dst_ptr;

    // Decode the element width and choose the address for the bus phase.
    always_comb begin
        step     = width_step(cfg_width);
        bus_size = width_size(cfg_width);
        bus_addr = bus_we ? dst_ptr : src_ptr;
    end

    dch_soft_rst #(.RST_CYC(RST_CYC)) u_srst (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (sw_rst_req),
        .busy (sw_rst_busy)
    );

    dch_ctrl #(.DW(DW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sw_rst_busy),
        .enable    (cfg_enable),
        .smode     (cfg_src_mode),
        .dmode     (cfg_dst_mode),
        .cfg_count (cfg_count),
        .trig_set  (trig_set),
        .prq_req   (prq_req),
        .bus_ready (bus_ready),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata),
        .trig_busy (trig_busy),
        .abort_flag(abort_flag),
        .cur_cnt   (cur_cnt),
        .load      (load),
        .src_adv   (src_adv),
        .dst_adv   (dst_adv),
        .wrap_evt  (wrap_evt),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .wdata     (bus_wdata),
        .prq_ack   (prq_ack),
        .done_evt  (done_evt)
    );

    dch_addr_gen #(.AW(AW)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_rst_busy),
        .load  (load),
        .adv   (src_adv),
        .reload(wrap_evt),
        .mode  (cfg_src_mode),
        .step  (step),
        .base  (cfg_src_base),
        .ptr   (src_ptr),
        .shown (cur_src)
    );

    dch_addr_gen #(.AW(AW)) u_dst (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_rst_busy),
        .load  (load),
        .adv   (dst_adv),
        .reload(wrap_evt),
        .mode  (cfg_dst_mode),
        .step  (step),
        .base  (cfg_dst_base),
        .ptr   (dst_ptr),
        .shown (cur_dst)
    );

endmodule

// File: rtl/dch_chk.sv
// Protocol checker for the DMA channel, attached to the top by bind.
// Observes ports only.
module dch_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          bus_ready,
    input logic          bus_err,
    input logic          prq_ack,
    input logic          done_evt,
    input logic          trig_busy,
    input logic          abort_flag,
    input logic          sw_rst_busy
);

    // R13
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready && !bus_err && !sw_rst_busy
        |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prq_ack |=> !prq_ack);

    // R6
    done_clears_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !trig_busy);

    // R8
    off_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable && !bus_req |=> !bus_req);

    // R10
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag && !sw_rst_busy |=> abort_flag);

    // R10
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag |-> !bus_req && !trig_busy);

    // R12
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_busy |=> !bus_req && !abort_flag && !trig_busy);

endmodule

bind periph_dma_chan dch_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_ready  (bus_ready),
    .bus_err    (bus_err),
    .prq_ack    (prq_ack),
    .done_evt   (done_evt),
    .trig_busy  (trig_busy),
    .abort_flag (abort_flag),
    .sw_rst_busy(sw_rst_busy)
);

// File: tb/periph_dma_chan_test.sv
// Self-checking bench: table-driven copy runs, then directed tests.
module periph_dma_chan_test;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0;
    logic [1:0]    cfg_src_mode = 2'b00;
    logic [1:0]    cfg_dst_mode = 2'b00;
    logic [1:0]    cfg_width = 2'b00;
    logic [AW-1:0] cfg_src_base = '0;
    logic [AW-1:0] cfg_dst_base = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          trig_set = 1'b0;
    logic          sw_rst_req = 1'b0;
    logic          trig_busy, sw_rst_busy, abort_flag, done_evt;
    logic [AW-1:0] cur_src, cur_dst;
    logic [CW-1:0] cur_cnt;
    logic          prq_req = 1'b0;
    logic          prq_ack;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b0;
    logic          bus_err = 1'b0;

    periph_dma_chan #(.AW(AW), .DW(DW), .CW(CW), .RST_CYC(3)) uut (.*);

    always #2 clk = ~clk;

    // Memory, reference image and environment counters.
    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];
    int  total = 0, bad = 0;
    int  ack_cnt = 0, done_cnt = 0, op_cnt = 0, size_bad = 0;
    int  ack_limit = 32'h7fffffff;
    logic [1:0] exp_size = 2'd2;
    logic       err_en = 1'b0;
    logic       err_we = 1'b0;
    logic [7:0] err_addr = '0;

    typedef struct packed {
        logic [1:0]  sm;
        logic [1:0]  dm;
        logic [1:0]  wd;
        logic [7:0]  sa;
        logic [7:0]  da;
        logic [15:0] n;
        logic [7:0]  csa;
        logic [7:0]  cda;
        logic [2:0]  step;
        logic        si;
        logic        di;
    } vec_t;

    // R2 R3 R5: width and mode cases with expected steps and last addresses.
    localparam vec_t VECS [7] = '{
        '{2'b00, 2'b00, 2'b00, 8'h00, 8'h80, 16'd4, 8'h0C, 8'h8C, 3'd4, 1'b1, 1'b1},
        '{2'b00, 2'b00, 2'b01, 8'h10, 8'h90, 16'd3, 8'h12, 8'h92, 3'd1, 1'b1, 1'b1},
        '{2'b00, 2'b00, 2'b10, 8'h20, 8'hA0, 16'd3, 8'h24, 8'hA4, 3'd2, 1'b1, 1'b1},
        '{2'b10, 2'b00, 2'b00, 8'h30, 8'hB0, 16'd3, 8'h30, 8'hB8, 3'd4, 1'b0, 1'b1},
        '{2'b00, 2'b10, 2'b01, 8'h40, 8'hC0, 16'd4, 8'h43, 8'hC0, 3'd1, 1'b1, 1'b0},
        '{2'b00, 2'b00, 2'b11, 8'h50, 8'hD0, 16'd2, 8'h54, 8'hD4, 3'd4, 1'b1, 1'b1},
        '{2'b01, 2'b00, 2'b00, 8'h60, 8'hE0, 16'd2, 8'h60, 8'hE4, 3'd4, 1'b0, 1'b1}
    };

    // Bus slave and peripheral model, acting away from the active edge.
    always @(negedge clk) begin
        if (bus_req && !bus_ready && !bus_err) begin
            if (bus_size != exp_size) size_bad = size_bad + 1;
            if (err_en && bus_addr[7:0] == err_addr && bus_we == err_we) begin
                bus_err = 1'b1;
            end else begin
                int nb;
                nb = (bus_size == 2'd0) ? 1 : (bus_size == 2'd1) ? 2 : 4;
                bus_ready = 1'b1;
                op_cnt = op_cnt + 1;
                bus_rdata = '0;
                for (int b = 0; b < nb; b++) begin
                    if (bus_we) mem[8'(bus_addr[7:0] + 8'(b))] = bus_wdata[8*b +: 8];
                    else bus_rdata[8*b +: 8] = mem[8'(bus_addr[7:0] + 8'(b))];
                end
            end
        end else begin
            bus_ready = 1'b0;
            bus_err = 1'b0;
        end
        if (done_evt) done_cnt = done_cnt + 1;
        if (prq_ack) begin
            ack_cnt = ack_cnt + 1;
            prq_req = 1'b0;
        end else begin
            prq_req = (ack_cnt < ack_limit);
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_set = 1'b1;
        @(negedge clk); trig_set = 1'b0;
    endtask

    task automatic soft_reset(output int busy_len);
        @(negedge clk); sw_rst_req = 1'b1;
        @(negedge clk); sw_rst_req = 1'b0;
        busy_len = 0;
        while (sw_rst_busy && busy_len < 20) begin
            busy_len++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int t = 0;
        while (trig_busy && t < 3000) begin
            t++;
            @(negedge clk);
        end
    endtask

    task automatic setup(input logic [1:0] sm, input logic [1:0] dm, input logic [1:0] wd,
                         input logic [7:0] sa, input logic [7:0] da, input logic [15:0] n);
        cfg_src_mode = sm; cfg_dst_mode = dm; cfg_width = wd;
        cfg_src_base = {24'h0, sa}; cfg_dst_base = {24'h0, da}; cfg_count = n;
        exp_size = (wd == 2'b01) ? 2'd0 : (wd == 2'b10) ? 2'd1 : 2'd2;
    endtask

    task automatic ref_copy(input logic [7:0] s, input logic [7:0] d, input int nb);
        for (int b = 0; b < nb; b++) ref_mem[8'(d + 8'(b))] = ref_mem[8'(s + 8'(b))];
    endtask

    function automatic int mem_diffs();
        int d = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) d++;
        return d;
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = (i < 128) ? 8'(i * 7 + 3) : 8'h00;
            ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!trig_busy && !bus_req && !prq_ack && !done_evt && !abort_flag && !sw_rst_busy,
            "R1 control outputs", {trig_busy, bus_req, abort_flag}, 0);
        chk(cur_src == 0 && cur_dst == 0 && cur_cnt == 0, "R1 current registers",
            cur_src | cur_dst | cur_cnt, 0);
        @(negedge clk); rst_n = 1'b1;
        cfg_enable = 1'b1;

        // Table of copy runs (R2 R3 R4 R5 R6)
        foreach (VECS[v]) begin
            int a0, d0, s0;
            a0 = ack_cnt; d0 = done_cnt; s0 = size_bad;
            setup(VECS[v].sm, VECS[v].dm, VECS[v].wd, VECS[v].sa, VECS[v].da, VECS[v].n);
            pulse_trig();
            wait_idle();
            cyc(2);
            for (int e = 0; e < int'(VECS[v].n); e++)
                ref_copy(8'(VECS[v].sa + (VECS[v].si ? e * VECS[v].step : 0)),
                         8'(VECS[v].da + (VECS[v].di ? e * VECS[v].step : 0)),
                         int'(VECS[v].step));
            chk(mem_diffs() == 0, $sformatf("R2 R3 vec%0d destination bytes", v), mem_diffs(), 0);
            chk(cur_src[7:0] == VECS[v].csa && cur_dst[7:0] == VECS[v].cda,
                $sformatf("R5 vec%0d last addresses", v), {cur_src[7:0], cur_dst[7:0]},
                {VECS[v].csa, VECS[v].cda});
            chk(ack_cnt - a0 == int'(VECS[v].n) && cur_cnt == 0,
                $sformatf("R4 vec%0d acks", v), ack_cnt - a0, VECS[v].n);
            chk(done_cnt - d0 == 1 && !trig_busy, $sformatf("R6 vec%0d done", v), done_cnt - d0, 1);
            chk(size_bad == s0, $sformatf("R2 vec%0d bus size", v), size_bad - s0, 0);
        end

        // R8: trigger while disabled waits without bus access
        begin
            int o0, a0, d0;
            o0 = op_cnt; a0 = ack_cnt; d0 = done_cnt;
            cfg_enable = 1'b0;
            setup(2'b00, 2'b00, 2'b00, 8'h08, 8'hEC, 16'd1);
            pulse_trig();
            cyc(12);
            chk(op_cnt == o0 && ack_cnt == a0 && trig_busy, "R8 disabled no access",
                op_cnt - o0, 0);
            cfg_enable = 1'b1;
            wait_idle(); cyc(2);
            ref_copy(8'h08, 8'hEC, 4);
            chk(ack_cnt - a0 == 1 && done_cnt - d0 == 1 && mem_diffs() == 0,
                "R6 starts once enabled", ack_cnt - a0, 1);
        end

        // R8: clearing enable while waiting ends the run
        begin
            int d0;
            d0 = done_cnt;
            ack_limit = ack_cnt;
            setup(2'b00, 2'b00, 2'b00, 8'h00, 8'hC4, 16'd3);
            pulse_trig(); cyc(4);
            cfg_enable = 1'b0;
            cyc(3);
            chk(!trig_busy && done_cnt == d0 && cur_cnt == 3, "R8 disable ends run",
                {trig_busy, cur_cnt}, 3);
            ack_limit = 32'h7fffffff;
            cfg_enable = 1'b1;
        end

        // R6: zero count completes at once without bus access
        begin
            int o0, d0;
            o0 = op_cnt; d0 = done_cnt;
            setup(2'b00, 2'b00, 2'b00, 8'h00, 8'hC4, 16'd0);
            pulse_trig(); cyc(4);
            chk(done_cnt - d0 == 1 && op_cnt == o0 && !trig_busy, "R6 zero count",
                done_cnt - d0, 1);
        end

        // R7: source wraps twice while destination keeps advancing
        begin
            int d0;
            d0 = done_cnt;
            ack_limit = ack_cnt + 5;
            setup(2'b11, 2'b00, 2'b00, 8'h00, 8'h80, 16'd2);
            pulse_trig();
            for (int t = 0; t < 400 && ack_cnt < ack_limit; t++) @(negedge clk);
            cyc(4);
            for (int k = 0; k < 5; k++) ref_copy(8'((k % 2) * 4), 8'(8'h80 + 4 * k), 4);
            chk(mem_diffs() == 0, "R7 wrap data", mem_diffs(), 0);
            chk(cur_cnt == 1 && cur_src == 0 && cur_dst == 32'h90, "R7 reload state",
                {cur_cnt, cur_src[7:0], cur_dst[7:0]}, {16'd1, 8'h00, 8'h90});
            chk(done_cnt == d0 && trig_busy, "R7 no done while wrapping", done_cnt - d0, 0);
            cfg_enable = 1'b0; cyc(3);
            chk(!trig_busy && done_cnt == d0, "R8 disable ends wrap", trig_busy, 0);
            ack_limit = 32'h7fffffff;
            cfg_enable = 1'b1;
        end

        // R9: enable dropped with a read in flight drops the data
        begin
            int a0, t;
            a0 = ack_cnt;
            setup(2'b00, 2'b00, 2'b00, 8'h00, 8'hF8, 16'd2);
            @(negedge clk); trig_set = 1'b1;
            @(negedge clk); trig_set = 1'b0;
            t = 0;
            while (!(bus_req && !bus_we) && t < 100) begin
                t++;
                @(negedge clk);
            end
            cfg_enable = 1'b0;
            cyc(4);
            chk(ack_cnt == a0 && cur_cnt == 2 && !trig_busy && mem_diffs() == 0,
                "R9 read dropped", {ack_cnt - a0, cur_cnt}, 2);
            cfg_enable = 1'b1;
        end

        // R10: read error aborts after one good element
        begin
            int a0, t;
            a0 = ack_cnt;
            err_en = 1'b1; err_we = 1'b0; err_addr = 8'h04;
            setup(2'b00, 2'b00, 2'b00, 8'h00, 8'hF0, 16'd3);
            pulse_trig();
            t = 0;
            while (!abort_flag && t < 200) begin
                t++;
                @(negedge clk);
            end
            cyc(3);
            err_en = 1'b0;
            ref_copy(8'h00, 8'hF0, 4);
            chk(abort_flag && !trig_busy && !bus_req, "R10 read abort", abort_flag, 1);
            chk(ack_cnt - a0 == 1 && cur_cnt == 2 && mem_diffs() == 0, "R10 read abort count",
                {ack_cnt - a0, cur_cnt}, {1, 2});
            pulse_trig(); cyc(3);
            chk(!trig_busy && abort_flag, "R11 trigger ignored in abort", trig_busy, 0);
        end

        // R12: software reset window and cleared state
        begin
            int len;
            soft_reset(len);
            chk(len == 3, "R12 reset window length", len, 3);
            chk(!abort_flag && !trig_busy && cur_src == 0 && cur_dst == 0 && cur_cnt == 0,
                "R12 state cleared", {abort_flag, cur_dst[7:0]}, 0);
        end

        // R10: write error aborts before any acknowledge
        begin
            int a0, t, len;
            a0 = ack_cnt;
            err_en = 1'b1; err_we = 1'b1; err_addr = 8'hF4;
            setup(2'b00, 2'b00, 2'b00, 8'h0C, 8'hF4, 16'd1);
            pulse_trig();
            t = 0;
            while (!abort_flag && t < 200) begin
                t++;
                @(negedge clk);
            end
            cyc(2);
            err_en = 1'b0;
            chk(abort_flag && ack_cnt == a0 && cur_cnt == 1 && cur_src == 32'h0C &&
                mem_diffs() == 0, "R10 write abort", {ack_cnt - a0, cur_cnt}, {0, 1});
            soft_reset(len);
            setup(2'b00, 2'b00, 2'b00, 8'h10, 8'hE8, 16'd1);
            a0 = ack_cnt;
            pulse_trig(); wait_idle(); cyc(2);
            ref_copy(8'h10, 8'hE8, 4);
            chk(ack_cnt - a0 == 1 && mem_diffs() == 0, "R12 runs after reset", ack_cnt - a0, 1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule